// File: doc/BRIEF.md
# Slot-Commanded MDIO Management Master

This block runs management frames on a two-wire MDC/MDIO bus. Software places packed 32-bit commands in two slots over a simple write/read register port. Each command word carries a completion flag, a frame-style bit, a two-bit opcode, a 5-bit port field, a 5-bit device or register field and a 16-bit payload. Writing a slot starts a frame. The master generates MDC from the system clock, sends the preamble and header, drives or releases MDIO during the turnaround, and moves the 16 payload bits.

An indirect (Clause 45) access takes two frames. First an address frame is placed in slot 0, which only arms the master. Writing the following read or write command to slot 1 then runs both frames back to back. Completion is reported in place: the flag in bit 31 of the slot that ran the last frame goes to 1, and for a read the returned 16 bits replace that slot's low half.

The sequencer states are S_IDLE, S_ARMED, S_RUN0, S_PAIR_ADDR and S_RUN1. Its transitions are:
- S_IDLE or S_ARMED on a slot-0 write of an indirect address command goes to S_ARMED ("arm").
- Any other slot-0 write goes to S_RUN0 ("solo0").
- A slot-1 write goes from S_IDLE to S_RUN1 ("solo1") and from S_ARMED to S_PAIR_ADDR ("pair").
- S_PAIR_ADDR on frame end goes to S_RUN1 ("chain").
- S_RUN0 or S_RUN1 on frame end goes to S_IDLE ("finish").

The frame engine has the states E_IDLE, E_SHIFT and E_TAIL. It goes from E_IDLE to E_SHIFT on a start, from E_SHIFT to E_TAIL when the last bit is sampled, and from E_TAIL back to E_IDLE on the final MDC falling edge.

Top module: `mdio_cmd_master`

## Requirements
- R1: Two 32-bit slots are written and read over the register port, with bus_sel=0 for slot 0 and bus_sel=1 for slot 1; bus_rdata shows the selected slot. A write stores bits 30:0 as given and clears bit 31 (done), whatever bit 31 of the written value is. Reset clears both slots.
- R2: A command with bit 28 = 1 (direct style) sends the following on MDIO, MSB first, one bit per MDC cycle: 32 ones, start pattern 01, opcode from bits 27:26, port from bits 25:21, register from bits 20:16, two turnaround bits, then 16 data bits.
- R3: A slot-0 write with bit 28 = 0 and opcode 00 only arms the master. There is no MDC activity and slot 0 bit 31 stays 0 until slot 1 is written. The address frame (start 00, payload = slot 0 bits 15:0) then runs, followed directly by the frame of slot 1.
- R4: In a chained pair, done and any read data appear in slot 1, and slot 0 bit 31 stays 0.
- R5: Opcode bit 27 = 1 marks a read. MDIO is released (mdio_oe=0) for frame bits 46 to 63, i.e. the turnaround and the data. The 16 bits are sampled on rising MDC, MSB first, and stored in bits 15:0 of the slot that ran the frame.
- R6: Opcode bit 27 = 0 marks a write. All 64 bits are driven, the turnaround is 1 then 0, and the slot's low half keeps the written payload.
- R7: A running slot reads bit 31 = 0, and it reads 1 once its frame has ended on the last MDC falling edge.
- R8: A write to either slot while a frame is in progress is ignored, and both slots keep their contents.
- R9: MDC stays HALF_DIV clock cycles high and HALF_DIV low, and it is held low while no frame runs. MDIO changes only while MDC is low, HOLD cycles after its falling edge.
- R10: Any slot-0 command other than an indirect address command, and any slot-1 command when no pair is armed, runs as a single frame that reports in its own slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Slot write strobe, one cycle |
| bus_sel | input | 1 | Slot select for write and read |
| bus_wdata | input | 32 | Command word to store |
| bus_rdata | output | 32 | Contents of the selected slot |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO drive enable |
| mdio_i | input | 1 | MDIO value seen on the line |

## Verification
The assertions assume that bus_we is a single-cycle strobe sampled on the clock, and that mdio_i carries meaningful data only while the master has released the line. They also assume that HOLD is smaller than HALF_DIV-1, so that every MDIO update falls strictly inside the MDC low phase. The bench keeps to this by issuing each slot write as a one-cycle pulse away from the clock edge. Its PHY model changes mdio_i only on MDC falling edges, and only in the data bits of read frames. Busy-time writes are placed deliberately in the middle of running frames.

// File: rtl/mdio_cmd_pkg.sv
package mdio_cmd_pkg;
    localparam int FRAME_LEN = 64;   // preamble + header + turnaround + data
    localparam int TA_POS    = 46;   // first turnaround bit index
    localparam int DATA_POS  = 48;   // first data bit index
    localparam int DONE_BIT  = 31;
    localparam int STYLE_BIT = 28;   // 1: direct style, 0: indirect style
    localparam int OPH_BIT   = 27;   // opcode MSB, 1 means read
    localparam int OPL_BIT   = 26;

    typedef enum logic [2:0] {
        S_IDLE, S_ARMED, S_RUN0, S_PAIR_ADDR, S_RUN1
    } seq_state_t;

    typedef enum logic [1:0] {
        E_IDLE, E_SHIFT, E_TAIL
    } eng_state_t;

    // Serial image of one frame, first bit transmitted is the MSB.
    function automatic logic [FRAME_LEN-1:0] build_frame(input logic [28:0] c);
        build_frame = {32'hFFFF_FFFF,
                       (c[STYLE_BIT] ? 2'b01 : 2'b00),
                       c[OPH_BIT:OPL_BIT],
                       c[25:21],
                       c[20:16],
                       2'b10,
                       c[15:0]};
    endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int HALF_DIV = 4,
    parameter int HOLD     = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic mdc,
    output logic upd_p,    // MDIO may change now (low phase, after margin)
    output logic smp_p,    // MDC rises at this edge: sample MDIO
    output logic fall_p    // MDC falls at this edge
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST   = CW'(HALF_DIV - 1);
    localparam logic [CW-1:0] HOLD_C = CW'(HOLD);

    logic [CW-1:0] cnt;
    logic          at_end;

    assign at_end = (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (!en) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (at_end) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign upd_p  = en && !mdc && (cnt == HOLD_C);
    assign smp_p  = en && !mdc && at_end;
    assign fall_p = en &&  mdc && at_end;
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_cmd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [28:0] cmd,
    input  logic        upd_p,
    input  logic        smp_p,
    input  logic        fall_p,
    input  logic        mdio_i,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic        active,
    output logic        done_p,
    output logic [15:0] rd_data
);
    localparam int IW = $clog2(FRAME_LEN);
    localparam logic [IW-1:0] LAST_IDX = IW'(FRAME_LEN - 1);

    eng_state_t           state, nxt;
    logic [FRAME_LEN-1:0] fv;
    logic                 is_rd;
    logic [IW-1:0]        idx;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= E_IDLE;
        else        state <= nxt;
    end

    // Next state
    always_comb begin
        nxt = state;
        unique case (state)
            E_IDLE:  if (start) nxt = E_SHIFT;
            E_SHIFT: if (smp_p && idx == LAST_IDX) nxt = E_TAIL;
            E_TAIL:  if (fall_p) nxt = E_IDLE;
            default: nxt = E_IDLE;
        endcase
    end

    // Outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fv      <= '0;
            is_rd   <= 1'b0;
            idx     <= '0;
            mdio_o  <= 1'b1;
            mdio_oe <= 1'b0;
            done_p  <= 1'b0;
            rd_data <= '0;
        end else begin
            done_p <= 1'b0;
            unique case (state)
                E_IDLE: begin
                    if (start) begin
                        fv    <= build_frame(cmd);
                        is_rd <= cmd[OPH_BIT];
                        idx   <= '0;
                    end
                end
                E_SHIFT: begin
                    if (upd_p) begin
                        mdio_o  <= fv[LAST_IDX - idx];
                        mdio_oe <= !(is_rd && idx >= IW'(TA_POS));
                    end
                    if (smp_p) begin
                        if (is_rd && idx >= IW'(DATA_POS))
                            rd_data <= {rd_data[14:0], mdio_i};
                        if (idx != LAST_IDX)
                            idx <= idx + 1'b1;
                    end
                end
                E_TAIL: begin
                    if (fall_p) begin
                        mdio_oe <= 1'b0;
                        done_p  <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign active = (state != E_IDLE);
endmodule

// File: rtl/mdio_cmd_master.sv
module mdio_cmd_master
    import mdio_cmd_pkg::*;
#(
    parameter int HALF_DIV = 4,
    parameter int HOLD     = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_we,
    input  logic        bus_sel,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    seq_state_t  state, nxt;
    logic [31:0] slot0, slot1;
    logic        go_q;
    logic        wr0, wr1, addr_cmd, busy;
    logic        in_run0, in_run1;
    logic [28:0] eng_cmd;
    logic        upd_p, smp_p, fall_p;
    logic        eng_active, fdone;
    logic [15:0] frd;
    logic        unused_wdata_done;

    assign unused_wdata_done = bus_wdata[DONE_BIT];

    assign wr0      = bus_we && !bus_sel;
    assign wr1      = bus_we &&  bus_sel;
    assign addr_cmd = !bus_wdata[STYLE_BIT] && (bus_wdata[OPH_BIT:OPL_BIT] == 2'b00);
    assign in_run0  = (state == S_RUN0);
    assign in_run1  = (state == S_RUN1);
    assign busy     = in_run0 || in_run1 || (state == S_PAIR_ADDR);
    assign eng_cmd  = in_run1 ? slot1[28:0] : slot0[28:0];
    assign bus_rdata = bus_sel ? slot1 : slot0;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // Next state
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE, S_ARMED: begin
                if (wr0)      nxt = addr_cmd ? S_ARMED : S_RUN0;
                else if (wr1) nxt = (state == S_ARMED) ? S_PAIR_ADDR : S_RUN1;
            end
            S_PAIR_ADDR:      if (fdone) nxt = S_RUN1;
            S_RUN0, S_RUN1:   if (fdone) nxt = S_IDLE;
            default:          nxt = S_IDLE;
        endcase
    end

    // Outputs: slot storage, completion status and frame launch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot0 <= '0;
            slot1 <= '0;
            go_q  <= 1'b0;
        end else begin
            go_q <= (nxt != state) &&
                    (nxt == S_RUN0 || nxt == S_PAIR_ADDR || nxt == S_RUN1);
            if (!busy && wr0) slot0 <= {1'b0, bus_wdata[30:0]};
            if (!busy && wr1) slot1 <= {1'b0, bus_wdata[30:0]};
            if (fdone && in_run0) begin
                slot0[DONE_BIT] <= 1'b1;
                if (slot0[OPH_BIT]) slot0[15:0] <= frd;
            end
            if (fdone && in_run1) begin
                slot1[DONE_BIT] <= 1'b1;
                if (slot1[OPH_BIT]) slot1[15:0] <= frd;
            end
        end
    end

    mdio_mdc_gen #(
        .HALF_DIV (HALF_DIV),
        .HOLD     (HOLD)
    ) u_mdc (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (eng_active),
        .mdc    (mdc),
        .upd_p  (upd_p),
        .smp_p  (smp_p),
        .fall_p (fall_p)
    );

    mdio_frame_engine u_eng (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (go_q),
        .cmd     (eng_cmd),
        .upd_p   (upd_p),
        .smp_p   (smp_p),
        .fall_p  (fall_p),
        .mdio_i  (mdio_i),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe),
        .active  (eng_active),
        .done_p  (fdone),
        .rd_data (frd)
    );
endmodule

// File: rtl/mdio_cmd_master_chk.sv
module mdio_cmd_master_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_we,
    input logic        busy,
    input logic        fdone,
    input logic        eng_active,
    input logic        mdc,
    input logic        mdio_o,
    input logic        in_run0,
    input logic        in_run1,
    input logic [31:0] slot0,
    input logic [31:0] slot1
);
    // R9: data line moves only inside the MDC low phase, after the margin
    a_r9_mdio_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdio_o) |-> (!mdc && !$past(mdc)));

    // R9: MDC parked low whenever no frame runs
    a_r9_mdc_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_active |-> !mdc);

    // R8: writes during a frame leave both slots untouched
    a_r8_busy_ignores_write: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_we && !fdone) |=> ($stable(slot0) && $stable(slot1)));

    // R7: the slot being executed reports not-done
    a_r7_done_low_run0: assert property (@(posedge clk) disable iff (!rst_n)
        in_run0 |-> !slot0[31]);

    a_r7_done_low_run1: assert property (@(posedge clk) disable iff (!rst_n)
        in_run1 |-> !slot1[31]);
endmodule

bind mdio_cmd_master mdio_cmd_master_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_we     (bus_we),
    .busy       (busy),
    .fdone      (fdone),
    .eng_active (eng_active),
    .mdc        (mdc),
    .mdio_o     (mdio_o),
    .in_run0    (in_run0),
    .in_run1    (in_run1),
    .slot0      (slot0),
    .slot1      (slot1)
);

// File: tb/mdio_cmd_master_bench.sv
`timescale 1ns/1ps
module mdio_cmd_master_bench;
    localparam int HALF_DIV = 4;
    localparam int HOLD     = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic        bus_sel = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        mdio_i = 1'b1;
    wire  [31:0] bus_rdata;
    wire         mdc, mdio_o, mdio_oe;

    always #2.5 clk = ~clk;

    mdio_cmd_master #(.HALF_DIV(HALF_DIV), .HOLD(HOLD)) u_mdio_cmd_master (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_sel(bus_sel),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i));

    int n_chk = 0;
    int n_bad = 0;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // ---------------- PHY model and line monitors ----------------
    int          cyc = 0;
    int          last_rise = 0;
    int          per_bad = 0;
    int          marg_bad = 0;
    int          bitn = 0;
    logic [63:0] cv = '0;
    logic [63:0] co = '0;
    logic [15:0] phy_data = '0;
    logic [63:0] fq[$];
    logic [63:0] oq[$];
    logic        prev_o = 1'b1;
    logic        prev_mdc = 1'b0;

    always @(negedge clk) cyc++;

    always @(posedge mdc) begin
        cv = {cv[62:0], (mdio_oe ? mdio_o : 1'b1)};
        co = {co[62:0], mdio_oe};
        if (bitn != 0 && (cyc - last_rise) != 2 * HALF_DIV) per_bad++;
        last_rise = cyc;
        if (bitn == 63) begin
            fq.push_back(cv);
            oq.push_back(co);
            bitn = 0;
        end else begin
            bitn++;
        end
    end

    always @(negedge mdc) begin
        if (bitn >= 48 && cv[bitn - 35]) mdio_i = phy_data[63 - bitn];
        else                             mdio_i = 1'b1;
    end

    always @(negedge clk) begin
        if (rst_n && (mdio_o !== prev_o) && (mdc || prev_mdc)) marg_bad++;
        prev_o   = mdio_o;
        prev_mdc = mdc;
    end

    // ---------------- expected-value functions ----------------
    function automatic logic [63:0] exp_frame(input logic [31:0] c);
        exp_frame = {32'hFFFF_FFFF, (c[28] ? 2'b01 : 2'b00), c[27:26], c[25:21], c[20:16],
                     (c[27] ? 18'h3FFFF : {2'b10, c[15:0]})};
    endfunction

    function automatic logic [63:0] exp_oe(input logic [31:0] c);
        exp_oe = c[27] ? {{46{1'b1}}, {18{1'b0}}} : {64{1'b1}};
    endfunction

    function automatic logic [31:0] exp_slot(input logic [31:0] c, input logic [15:0] pd);
        exp_slot = {1'b1, c[30:16], (c[27] ? pd : c[15:0])};
    endfunction

    function automatic logic [31:0] rnd_direct(input logic rdop);
        rnd_direct = {$urandom_range(1, 0) == 1, 2'($urandom_range(3, 0)), 1'b1,
                      (rdop ? 2'b11 : 2'b01), 5'($urandom_range(31, 0)),
                      5'($urandom_range(31, 0)), 16'($urandom_range(65535, 0))};
    endfunction

    // ---------------- bus tasks ----------------
    task automatic bus_write(input logic s, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_sel = s; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic s, output logic [31:0] d);
        @(negedge clk);
        bus_sel = s;
        #1 d = bus_rdata;
    endtask

    task automatic wait_done(input logic s);
        logic [31:0] v;
        for (int k = 0; k < 4000; k++) begin
            bus_read(s, v);
            if (v[31]) break;
        end
    endtask

    task automatic check_frames(input string req, input int n,
                                input logic [31:0] c0, input logic [31:0] c1);
        check({req, " frame count"}, 64'(fq.size()), 64'(n));
        if (fq.size() == n && n > 0) begin
            check({req, " frame bits"}, fq[0], exp_frame(c0));
            check({req, " drive mask"}, oq[0], exp_oe(c0));
            if (n == 2) begin
                check({req, " second frame bits"}, fq[1], exp_frame(c1));
                check({req, " second drive mask"}, oq[1], exp_oe(c1));
            end
        end
    endtask

    logic [31:0] exp_s1 = '0;

    task automatic solo(input logic s, input logic [31:0] c, input logic [15:0] pd,
                        input string tag);
        logic [31:0] v;
        phy_data = pd;
        fq.delete(); oq.delete();
        bus_write(s, c);
        wait_done(s);
        bus_read(s, v);
        check({tag, " R1 R7 slot readback"}, 64'(v), 64'(exp_slot(c, pd)));
        check_frames(tag, 1, c, 32'h0);
        if (s) exp_s1 = exp_slot(c, pd);
    endtask

    task automatic pair(input logic [31:0] a, input logic [31:0] b, input logic [15:0] pd,
                        input string tag);
        logic [31:0] v;
        phy_data = pd;
        fq.delete(); oq.delete();
        bus_write(1'b0, a);
        repeat (60) @(negedge clk);
        check("R3 armed: no frame yet", 64'(fq.size()), 64'd0);
        check("R3 armed: MDC low", 64'(mdc), 64'd0);
        bus_read(1'b0, v);
        check("R3 armed: slot0 pending", 64'(v), 64'({1'b0, a[30:0]}));
        bus_write(1'b1, b);
        wait_done(1'b1);
        bus_read(1'b1, v);
        check({tag, " R4 slot1 readback"}, 64'(v), 64'(exp_slot(b, pd)));
        bus_read(1'b0, v);
        check("R4 slot0 done stays 0", 64'(v), 64'({1'b0, a[30:0]}));
        check_frames({tag, " R3"}, 2, a, b);
        exp_s1 = exp_slot(b, pd);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(5.0 * 190000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual run still going, expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        logic [31:0] v, a, b, c;
        logic [4:0]  pa, da;
        void'($urandom(32'd7041));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        bus_read(1'b0, v); check("R1 reset slot0", 64'(v), 64'd0);
        bus_read(1'b1, v); check("R1 reset slot1", 64'(v), 64'd0);
        check("R9 reset MDC low", 64'(mdc), 64'd0);
        check("R9 reset MDIO released", 64'(mdio_oe), 64'd0);

        // Directed corners: extreme fields, done bit written as 1
        solo(1'b0, {1'b1, 2'b10, 1'b1, 2'b01, 5'd31, 5'd0, 16'hFFFF}, 16'h0, "R2 R6");
        solo(1'b0, {1'b0, 2'b01, 1'b1, 2'b01, 5'd0, 5'd31, 16'h0000}, 16'h0, "R2 R6");
        solo(1'b0, {1'b1, 2'b00, 1'b1, 2'b11, 5'd17, 5'd9, 16'h1234}, 16'hA5C3, "R2 R5");
        solo(1'b0, {1'b0, 2'b11, 1'b1, 2'b11, 5'd1, 5'd2, 16'h0000}, 16'hFFFF, "R2 R5");
        solo(1'b0, {1'b0, 2'b00, 1'b1, 2'b11, 5'd3, 5'd4, 16'hFFFF}, 16'h0000, "R2 R5");

        // Indirect pairs
        pair({1'b0, 2'b01, 1'b0, 2'b00, 5'd5, 5'd1, 16'hBEEF},
             {1'b1, 2'b01, 1'b0, 2'b11, 5'd5, 5'd1, 16'h0000}, 16'h5A96, "R5");
        pair({1'b1, 2'b00, 1'b0, 2'b00, 5'd31, 5'd31, 16'h0000},
             {1'b0, 2'b10, 1'b0, 2'b01, 5'd31, 5'd31, 16'hC001}, 16'h0, "R6");

        // Single frames outside the pair rule
        solo(1'b1, {1'b0, 2'b00, 1'b1, 2'b01, 5'd8, 5'd7, 16'h7E57}, 16'h0, "R10");
        solo(1'b0, {1'b0, 2'b00, 1'b0, 2'b11, 5'd2, 5'd3, 16'h0000}, 16'h3C3C, "R10 R5");
        solo(1'b1, {1'b0, 2'b00, 1'b0, 2'b10, 5'd6, 5'd30, 16'h0000}, 16'h8001, "R10 R5");

        // Busy-time writes and the running done flag
        c = {1'b0, 2'b00, 1'b1, 2'b01, 5'd12, 5'd13, 16'h4242};
        fq.delete(); oq.delete();
        bus_write(1'b0, c);
        repeat (100) @(negedge clk);
        bus_read(1'b0, v);
        check("R7 done low while running", 64'(v[31]), 64'd0);
        bus_write(1'b1, 32'hFFFF_FFFF);
        bus_write(1'b0, 32'h1357_9BDF);
        wait_done(1'b0);
        bus_read(1'b0, v);
        check("R8 slot0 kept through busy write", 64'(v), 64'(exp_slot(c, 16'h0)));
        bus_read(1'b1, v);
        check("R8 slot1 kept through busy write", 64'(v), 64'(exp_s1));
        check_frames("R8", 1, c, 32'h0);

        // Random mix
        for (int i = 0; i < 30; i++) begin
            int kind;
            logic [15:0] pd;
            kind = $urandom_range(3, 0);
            pd   = 16'($urandom_range(65535, 0));
            pa   = 5'($urandom_range(31, 0));
            da   = 5'($urandom_range(31, 0));
            if (kind == 0) begin
                solo(1'b0, rnd_direct($urandom_range(1, 0) == 1), pd, "R2 R5 R6");
            end else if (kind == 1) begin
                solo(1'b1, rnd_direct($urandom_range(1, 0) == 1), pd, "R10 R2");
            end else begin
                a = {1'($urandom_range(1, 0)), 2'($urandom_range(3, 0)), 1'b0, 2'b00,
                     pa, da, 16'($urandom_range(65535, 0))};
                b = {1'($urandom_range(1, 0)), 2'($urandom_range(3, 0)), 1'b0,
                     2'($urandom_range(3, 1)), pa, da, 16'($urandom_range(65535, 0))};
                pair(a, b, pd, "R4 R5 R6");
            end
        end

        check("R9 MDC period", 64'(per_bad), 64'd0);
        check("R9 MDIO change margin", 64'(marg_bad), 64'd0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule